// File: doc/BRIEF.md
# Rank Interleave Address Decoder

This block turns a channel-local memory address into the rank that holds it, the DIMM slot of that rank, and the address within the rank. It sits after the stage that strips socket and channel interleave from a system address. The stage that splits the rank address into bank, row and column uses its results.

Configuration arrives as a table of rules. Each rule has an upper address limit and four way slots. Each slot names a rank and carries a signed offset, counted in virtual-rank units of 2^VRANK_SHIFT bytes. A rule covers the range from the previous rule's limit up to its own limit. The first rule that covers the address is used. A page-policy input decides which two address bits pick the slot. The rule's interleave factor is derived from how many slots repeat the rank of slot 0. The result is registered and appears one cycle after the request.

Top module: `rank_ilv_decoder`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R2: Rule r covers addresses in the range L(r-1) <= addr < L(r), where L(-1) is 0 and L(r) is the limit of rule r. The lowest-numbered covering rule wins, so a rule whose limit does not exceed the previous limit never matches.
- R3: With `closed_page` high, the way slot is addr[7:6] and bits [5:0] of the rank address equal addr[5:0].
- R4: With `closed_page` low, the way slot is addr[13:12] and bits [11:0] of the rank address equal addr[11:0].
- R5: The interleave factor is 1 when slots 1, 2 and 3 all hold the rank of slot 0. It is 2 when at least one of them does. It is 4 when none does.
- R6: The rank address is ((addr + offset*2^VRANK_SHIFT) mod 2^ADDR_W) / factor. The kept low bits (R3/R4) are then replaced by those of addr. The offset is the selected slot's signed two's-complement value.
- R7: On a hit, `out_rank` is the selected slot's rank and `out_dimm` is `out_rank` shifted right by two.
- R8: When no rule covers the address, `out_hit` is low and `out_rank`, `out_dimm` and `out_raddr` are all ones. Reset leaves the same values with `out_valid` low.
- R9: In the cycle after `in_valid` is low, `out_hit`, `out_rank`, `out_dimm` and `out_raddr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_caddr | input | ADDR_W | Channel address to decode |
| closed_page | input | 1 | Page policy: 1 closed (way from bits 7:6), 0 open (way from bits 13:12) |
| rule_limit | input | NUM_RULES*ADDR_W | Exclusive upper limit of each rule, rule r at bits r*ADDR_W |
| way_rank | input | NUM_RULES*4*RANK_W | Rank of each slot, rule r slot w at bits (4r+w)*RANK_W |
| way_offset | input | NUM_RULES*4*OFF_W | Signed virtual-rank offset of each slot, same ordering |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_hit | output | 1 | A rule covered the address |
| out_rank | output | RANK_W | Decoded rank, all ones on miss |
| out_dimm | output | RANK_W-2 | DIMM index, all ones on miss |
| out_raddr | output | ADDR_W | Rank-local address, all ones on miss |

## Verification
All outputs are due on the first rising edge after the edge that captured a request. None of them arrives later. The bench changes inputs on a falling edge and reads the results on the next falling edge. That point is half a period after the only register stage, so every check sees exactly one registered result. Idle cycles are checked on the same edge to show that the previous result is held and the strobe falls. Expected ranks come from a hand-made table. The rank addresses come from an arithmetic model in the bench built from R5 and R6.

// File: rtl/rid_pkg.sv
package rid_pkg;
   localparam int WAYS           = 4;
   localparam int CLOSED_WAY_LSB = 6;
   localparam int OPEN_WAY_LSB   = 12;

   // encoded value equals the right shift applied for the factor
   typedef enum logic [1:0] {
      IL_ONE  = 2'd0,
      IL_TWO  = 2'd1,
      IL_FOUR = 2'd2
   } il_e;
endpackage

// File: rtl/rid_rule_match.sv
module rid_rule_match #(
   parameter int ADDR_W    = 37,
   parameter int NUM_RULES = 4,
   localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
   input  logic [ADDR_W-1:0]           caddr,
   input  logic [NUM_RULES*ADDR_W-1:0] limits,
   output logic                        hit,
   output logic [IDX_W-1:0]            idx
);
   logic [ADDR_W-1:0] lo;

   always_comb begin
      hit = 1'b0;
      idx = '0;
      lo  = '0;
      for (int r = 0; r < NUM_RULES; r++) begin
         if (!hit && caddr >= lo && caddr < limits[r*ADDR_W +: ADDR_W]) begin
            hit = 1'b1;
            idx = IDX_W'(r);
         end
         lo = limits[r*ADDR_W +: ADDR_W];
      end
   end
endmodule

// File: rtl/rid_ilv_classify.sv
module rid_ilv_classify
   import rid_pkg::*;
#(
   parameter int RANK_W = 4
) (
   input  logic [WAYS*RANK_W-1:0] ranks,
   output il_e                    il
);
   logic [WAYS-2:0] same;

   for (genvar w = 1; w < WAYS; w++) begin : g_cmp
      assign same[w-1] = (ranks[w*RANK_W +: RANK_W] == ranks[0 +: RANK_W]);
   end

   always_comb begin
      if (&same)      il = IL_ONE;
      else if (|same) il = IL_TWO;
      else            il = IL_FOUR;
   end
endmodule

// File: rtl/rid_raddr_calc.sv
module rid_raddr_calc
   import rid_pkg::*;
#(
   parameter int ADDR_W      = 37,
   parameter int OFF_W       = 12,
   parameter int VRANK_SHIFT = 16
) (
   input  logic [ADDR_W-1:0] caddr,
   input  logic [OFF_W-1:0]  offset,
   input  il_e               il,
   input  logic              closed_page,
   output logic [ADDR_W-1:0] raddr
);
   localparam logic [ADDR_W-1:0] KEEP_CLOSED = {{(ADDR_W-CLOSED_WAY_LSB){1'b0}}, {CLOSED_WAY_LSB{1'b1}}};
   localparam logic [ADDR_W-1:0] KEEP_OPEN   = {{(ADDR_W-OPEN_WAY_LSB){1'b0}}, {OPEN_WAY_LSB{1'b1}}};

   logic [ADDR_W-1:0] off_ext, sum, quot, keep;
   logic [1:0]        shamt;

   assign off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset} << VRANK_SHIFT;
   assign sum     = caddr + off_ext;
   assign shamt   = il;
   assign quot    = sum >> shamt;
   assign keep    = closed_page ? KEEP_CLOSED : KEEP_OPEN;
   assign raddr   = (quot & ~keep) | (caddr & keep);
endmodule

// File: rtl/rank_ilv_decoder.sv
module rank_ilv_decoder
   import rid_pkg::*;
#(
   parameter int ADDR_W      = 37,
   parameter int NUM_RULES   = 4,
   parameter int RANK_W      = 4,
   parameter int OFF_W       = 12,
   parameter int VRANK_SHIFT = 16,
   localparam int DIMM_W     = RANK_W - 2,
   localparam int IDX_W      = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   input  logic [ADDR_W-1:0]                in_caddr,
   input  logic                             closed_page,
   input  logic [NUM_RULES*ADDR_W-1:0]      rule_limit,
   input  logic [NUM_RULES*WAYS*RANK_W-1:0] way_rank,
   input  logic [NUM_RULES*WAYS*OFF_W-1:0]  way_offset,
   output logic                             out_valid,
   output logic                             out_hit,
   output logic [RANK_W-1:0]                out_rank,
   output logic [DIMM_W-1:0]                out_dimm,
   output logic [ADDR_W-1:0]                out_raddr
);
   // elaboration-time parameter checks
   if (ADDR_W < OPEN_WAY_LSB + 2) begin : g_bad_addr
      $error("ADDR_W too small for open-page way bits");
   end
   if (OFF_W >= ADDR_W) begin : g_bad_off
      $error("OFF_W must be narrower than ADDR_W");
   end
   if (VRANK_SHIFT >= ADDR_W) begin : g_bad_vrank
      $error("VRANK_SHIFT must be below ADDR_W");
   end
   if (RANK_W < 3) begin : g_bad_rank
      $error("RANK_W must leave at least one DIMM bit");
   end
   if (NUM_RULES < 1) begin : g_bad_rules
      $error("NUM_RULES must be at least one");
   end

   logic             hit;
   logic [IDX_W-1:0] idx;
   logic [1:0]       way;
   il_e              il_r [NUM_RULES];
   il_e              sel_il;
   logic [RANK_W-1:0] sel_rank;
   logic [OFF_W-1:0]  sel_off;
   logic [ADDR_W-1:0] raddr;

   rid_rule_match #(.ADDR_W(ADDR_W), .NUM_RULES(NUM_RULES)) u_match (
      .caddr (in_caddr),
      .limits(rule_limit),
      .hit   (hit),
      .idx   (idx)
   );

   for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
      rid_ilv_classify #(.RANK_W(RANK_W)) u_cls (
         .ranks(way_rank[r*WAYS*RANK_W +: WAYS*RANK_W]),
         .il   (il_r[r])
      );
   end

   assign way = closed_page ? in_caddr[CLOSED_WAY_LSB +: 2] : in_caddr[OPEN_WAY_LSB +: 2];

   always_comb begin
      sel_il   = IL_ONE;
      sel_rank = '0;
      sel_off  = '0;
      for (int r = 0; r < NUM_RULES; r++) begin
         if (idx == IDX_W'(r)) begin
            sel_il = il_r[r];
            for (int w = 0; w < WAYS; w++) begin
               if (way == 2'(w)) begin
                  sel_rank = way_rank[(r*WAYS+w)*RANK_W +: RANK_W];
                  sel_off  = way_offset[(r*WAYS+w)*OFF_W +: OFF_W];
               end
            end
         end
      end
   end

   rid_raddr_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VRANK_SHIFT(VRANK_SHIFT)) u_calc (
      .caddr      (in_caddr),
      .offset     (sel_off),
      .il         (sel_il),
      .closed_page(closed_page),
      .raddr      (raddr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hit   <= 1'b0;
         out_rank  <= '1;
         out_dimm  <= '1;
         out_raddr <= '1;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_hit   <= hit;
            out_rank  <= hit ? sel_rank : '1;
            out_dimm  <= hit ? sel_rank[RANK_W-1:2] : '1;
            out_raddr <= hit ? raddr : '1;
         end
      end
   end
endmodule

// File: rtl/rid_checker.sv
module rid_checker #(
   parameter int ADDR_W = 37,
   parameter int RANK_W = 4,
   localparam int DIMM_W = RANK_W - 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ADDR_W-1:0] in_caddr,
   input logic              closed_page,
   input logic [ADDR_W-1:0] lim0,
   input logic              out_valid,
   input logic              out_hit,
   input logic [RANK_W-1:0] out_rank,
   input logic [DIMM_W-1:0] out_dimm,
   input logic [ADDR_W-1:0] out_raddr
);
   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R2
   first_rule_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_caddr < lim0) |=> out_hit);
   // R3
   closed_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && closed_page) |=> (!out_hit || out_raddr[5:0] == $past(in_caddr[5:0])));
   // R4
   open_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !closed_page) |=> (!out_hit || out_raddr[11:0] == $past(in_caddr[11:0])));
   // R7
   dimm_of_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_hit) |-> out_dimm == out_rank[RANK_W-1:2]);
   // R8
   miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_hit) |-> (&out_rank && &out_dimm && &out_raddr));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_hit) && $stable(out_rank) && $stable(out_dimm) && $stable(out_raddr)));
endmodule

bind rank_ilv_decoder rid_checker #(.ADDR_W(ADDR_W), .RANK_W(RANK_W)) u_rid_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_caddr   (in_caddr),
   .closed_page(closed_page),
   .lim0       (rule_limit[ADDR_W-1:0]),
   .out_valid  (out_valid),
   .out_hit    (out_hit),
   .out_rank   (out_rank),
   .out_dimm   (out_dimm),
   .out_raddr  (out_raddr)
);

// File: tb/rank_ilv_decoder_test.sv
`timescale 1ns/1ps
module rank_ilv_decoder_test;
   localparam int AW = 37, NR = 4, RW = 4, OW = 12, VS = 16, DW = RW - 2;
   localparam logic [63:0] MASK = (64'd1 << AW) - 1;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, closed_page = 1'b1;
   logic [AW-1:0] in_caddr = '0;
   logic [NR*AW-1:0] rule_limit;
   logic [NR*4*RW-1:0] way_rank;
   logic [NR*4*OW-1:0] way_offset;
   logic out_valid, out_hit;
   logic [RW-1:0] out_rank;
   logic [DW-1:0] out_dimm;
   logic [AW-1:0] out_raddr;

   longint lim [NR];
   int     rk  [NR][4];
   int     of  [NR][4];
   int     checks = 0, failures = 0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int r = 0; r < NR; r++) begin
         rule_limit[r*AW +: AW] = AW'(lim[r]);
         for (int w = 0; w < 4; w++) begin
            way_rank[(r*4+w)*RW +: RW]   = RW'(rk[r][w]);
            way_offset[(r*4+w)*OW +: OW] = OW'(of[r][w]);
         end
      end
   end

   rank_ilv_decoder #(.ADDR_W(AW), .NUM_RULES(NR), .RANK_W(RW), .OFF_W(OW), .VRANK_SHIFT(VS)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_caddr(in_caddr),
      .closed_page(closed_page), .rule_limit(rule_limit), .way_rank(way_rank),
      .way_offset(way_offset), .out_valid(out_valid), .out_hit(out_hit),
      .out_rank(out_rank), .out_dimm(out_dimm), .out_raddr(out_raddr)
   );

   // stimulus table: address, closed-page flag, expected hit, expected rank
   localparam int NV = 10;
   localparam logic [63:0] V_ADDR [NV] = '{64'h0C5, 64'h150080, 64'h1500C0, 64'h153000,
      64'h800040, 64'h802000, 64'h1000000, 64'h3FFFFF, 64'h400000, 64'hFFFFF};
   localparam bit V_CLOSED [NV] = '{1, 1, 1, 0, 1, 0, 1, 0, 1, 1};
   localparam bit V_HIT    [NV] = '{1, 1, 1, 1, 1, 1, 0, 1, 1, 1};
   localparam int V_RANK   [NV] = '{5, 2, 3, 3, 9, 10, 15, 3, 8, 5};

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // model of the rank address from the factor and offset rules
   function automatic logic [63:0] model_raddr(input logic [63:0] a, input bit cl);
      logic [63:0] lo, sum, q, km;
      int w, n, sh;
      lo = 0;
      for (int r = 0; r < NR; r++) begin
         if (a >= lo && a < 64'(lim[r])) begin
            w = cl ? int'(a[7:6]) : int'(a[13:12]);
            n = 0;
            for (int k = 1; k < 4; k++) if (rk[r][k] == rk[r][0]) n++;
            sh  = (n == 3) ? 0 : (n >= 1) ? 1 : 2;
            sum = (a + 64'(longint'(of[r][w]) <<< VS)) & MASK;
            q   = sum >> sh;
            km  = cl ? 64'h3F : 64'hFFF;
            return ((q & ~km) | (a & km)) & MASK;
         end
         lo = 64'(lim[r]);
      end
      return MASK;
   endfunction

   task automatic apply(input logic [63:0] a, input bit cl);
      @(negedge clk);
      in_valid = 1'b1; in_caddr = AW'(a); closed_page = cl;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      lim[0] = 64'h100000;  rk[0] = '{5, 5, 5, 5};     of[0] = '{0, 0, 0, 0};
      lim[1] = 64'h400000;  rk[1] = '{2, 3, 2, 3};     of[1] = '{0, 0, -4, -4};
      lim[2] = 64'h1000000; rk[2] = '{8, 9, 10, 11};   of[2] = '{-16, -16, -16, -16};
      lim[3] = 64'h800000;  rk[3] = '{1, 1, 1, 1};     of[3] = '{0, 0, 0, 0};

      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 reset valid", 64'(out_valid), 0);
      check("R8 reset rank", 64'(out_rank), 64'hF);
      check("R8 reset raddr", 64'(out_raddr), MASK);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6 R7 R8 table walk
      for (int i = 0; i < NV; i++) begin
         apply(V_ADDR[i], V_CLOSED[i]);
         check("R1 valid", 64'(out_valid), 1);
         check("R2 hit", 64'(out_hit), 64'(V_HIT[i]));
         check("R7 rank", 64'(out_rank), 64'(V_RANK[i]));
         check("R7 dimm", 64'(out_dimm), V_HIT[i] ? 64'(V_RANK[i] >> 2) : 64'h3);
         check(V_CLOSED[i] ? "R3 R6 raddr" : "R4 R6 raddr", 64'(out_raddr), model_raddr(V_ADDR[i], V_CLOSED[i]));
      end

      // R9 idle input: results held, strobe low
      in_caddr = AW'(64'h123);
      @(negedge clk);
      check("R1 idle valid", 64'(out_valid), 0);
      check("R9 hold rank", 64'(out_rank), 5);
      check("R9 hold raddr", 64'(out_raddr), model_raddr(64'hFFFFF, 1));

      // R5 factor four when no slot repeats slot 0's rank
      rk[0] = '{5, 6, 7, 4};
      apply(64'h234C0, 1);
      check("R5 rank", 64'(out_rank), 4);
      check("R5 raddr", 64'(out_raddr), 64'h8D00);

      // R6 negative offset wraps modulo the address width
      rk[0] = '{5, 5, 5, 5}; of[0] = '{-1, -1, -1, -1};
      apply(64'h40, 1);
      check("R6 wrap raddr", 64'(out_raddr), 64'h1FFFFF0040);

      // R2 rule with limit below its predecessor never matches
      apply(64'h900000, 0);
      check("R2 skip rank", 64'(out_rank), 64'(rk[2][int'(64'h900000 >> 12) & 3]));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule